// File: doc/BRIEF.md
# Dual-Channel Match Compare Timer

This block holds two independent 32-bit up-counters, each paired with a compare value. When a running channel's counter equals its compare value, the channel's pending flag sets. The flag then drives that channel's interrupt line if the channel's interrupt enable is on. Both pending flags sit in one status word that software clears by writing ones. The timer clock is used undivided.

Software schedules an event in four steps. It stops the channel, writes zero to its counter, loads the wanted delta into the compare register, and then sets the count-enable and interrupt-enable bits together. The event fires delta+1 clock edges after the start write. A flat register port with a one-cycle write strobe and combinational read data gives access to every register.

Top module: `dual_match_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and both interrupt lines are low.
- R2: While bit 0 of a channel's control word is 1, its counter rises by one on every clock edge and wraps from 0xFFFFFFFF to 0.
- R3: While bit 0 of a channel's control word is 0, the counter holds its value. Writing 0 to the control word stops the channel and masks its interrupt.
- R4: When a channel is counting and its counter equals its compare value, status bit n of that channel sets on the next clock edge. Starting from a cleared counter with delta D, the flag sets D+1 edges after the start write.
- R5: The interrupt line of channel n is its status bit ANDed with bit 1 of its control word. The status bit sets whether or not bit 1 is on.
- R6: The channels are independent. A compare event on one channel changes neither the other channel's status bit nor its interrupt line.
- R7: Writing the status word clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing 0xFFFF clears every flag.
- R8: The smallest delta, 2, works. From a cleared counter it raises the flag on exactly the third edge after the start write, and not before.
- R9: A software write to a counter takes priority over the increment of that cycle. The written value appears unchanged on the next read.
- R10: When a compare event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R11: The register map is as follows: control n at 0x00+4n (bits 2:0 stored, higher bits read 0), compare n at 0x18+4n, counter n at 0x48+4n, status at 0x60 (bit n = channel n). Any other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 2 | Per-channel interrupt, bit n = channel n |

## Verification
The assertions assume that a write strobe lasts exactly one clock and carries stable data. They also assume that software never writes a counter in the same cycle it expects an increment. The directed stimulus applies every access as a single-cycle pulse between falling edges. It writes a counter only to test that the write takes priority, and it lines up the one same-cycle set/clear race on purpose, by starting a channel whose counter already equals its compare value.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
// mct_pkg: shared sizes and register offsets for the match compare timer.
// Assumes byte addressing with a 4-byte stride between per-channel registers.
package mct_pkg;
    localparam int MCT_ADDR_W    = 8;
    localparam int MCT_DATA_W    = 32;
    localparam int MCT_NUM_CH    = 2;
    localparam int MCT_CTRL_W    = 3;
    localparam int MCT_STRIDE    = 4;

    localparam int MCT_CTRL_BASE  = 'h00;
    localparam int MCT_MATCH_BASE = 'h18;
    localparam int MCT_COUNT_BASE = 'h48;
    localparam int MCT_STAT_OFF   = 'h60;

    // Control bit positions
    localparam int MCT_BIT_RUN = 0;
    localparam int MCT_BIT_IE  = 1;
endpackage

// File: rtl/mct_regif.sv
`timescale 1ns/1ps
// mct_regif: address decode and read multiplexer.
// Produces one-cycle write strobes per register and combinational read data.
// Assumes bus_sel is a single-cycle pulse per access; undecoded reads give 0.
module mct_regif #(
    parameter int ADDR_W = mct_pkg::MCT_ADDR_W,
    parameter int DATA_W = mct_pkg::MCT_DATA_W,
    parameter int NUM_CH = mct_pkg::MCT_NUM_CH,
    parameter int CTRL_W = mct_pkg::MCT_CTRL_W
) (
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [NUM_CH-1:0][CTRL_W-1:0]     ctrl_q,
    input  logic [NUM_CH-1:0][DATA_W-1:0]     match_q,
    input  logic [NUM_CH-1:0][DATA_W-1:0]     count_q,
    input  logic [NUM_CH-1:0]                 status_q,
    output logic [NUM_CH-1:0]                 ctrl_we,
    output logic [NUM_CH-1:0]                 match_we,
    output logic [NUM_CH-1:0]                 count_we,
    output logic                              status_we,
    output logic [DATA_W-1:0]                 bus_rdata
);
    import mct_pkg::*;

    logic                wr_strobe;
    logic [NUM_CH-1:0]   hit_ctrl;
    logic [NUM_CH-1:0]   hit_match;
    logic [NUM_CH-1:0]   hit_count;
    logic                hit_stat;

    assign wr_strobe = bus_sel && bus_wr;

    // Per-channel address comparators
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
            assign hit_ctrl[c]  = (bus_addr == ADDR_W'(MCT_CTRL_BASE  + MCT_STRIDE * c));
            assign hit_match[c] = (bus_addr == ADDR_W'(MCT_MATCH_BASE + MCT_STRIDE * c));
            assign hit_count[c] = (bus_addr == ADDR_W'(MCT_COUNT_BASE + MCT_STRIDE * c));
            assign ctrl_we[c]   = wr_strobe && hit_ctrl[c];
            assign match_we[c]  = wr_strobe && hit_match[c];
            assign count_we[c]  = wr_strobe && hit_count[c];
        end
    endgenerate

    assign hit_stat  = (bus_addr == ADDR_W'(MCT_STAT_OFF));
    assign status_we = wr_strobe && hit_stat;

    // Read multiplexer: OR of all decoded sources, zero when nothing matches
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit_ctrl[c])  bus_rdata = bus_rdata | DATA_W'(ctrl_q[c]);
            if (hit_match[c]) bus_rdata = bus_rdata | match_q[c];
            if (hit_count[c]) bus_rdata = bus_rdata | count_q[c];
        end
        if (hit_stat) bus_rdata = bus_rdata | DATA_W'(status_q);
    end
endmodule

// File: rtl/mct_channel.sv
`timescale 1ns/1ps
// mct_channel: one compare channel with a control word, a compare value and
// an up-counter that software can write. It flags a compare hit while running.
// Assumes the strobes come from mct_regif and last one cycle.
module mct_channel #(
    parameter int CNT_W  = mct_pkg::MCT_DATA_W,
    parameter int CTRL_W = mct_pkg::MCT_CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              match_we,
    input  logic              count_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [CNT_W-1:0]  match_q,
    output logic [CNT_W-1:0]  count_q,
    output logic              hit,
    output logic              irq_en
);
    import mct_pkg::*;

    logic count_en;

    assign count_en = ctrl_q[MCT_BIT_RUN];
    assign irq_en   = ctrl_q[MCT_BIT_IE];
    assign hit      = count_en && (count_q == match_q);

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wdata;
    end

    // Compare value register
    always_ff @(posedge clk) begin
        if (!rst_n)        match_q <= '0;
        else if (match_we) match_q <= wdata;
    end

    // Counter: a software write beats the increment
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (count_we) count_q <= wdata;
        else if (count_en) count_q <= count_q + CNT_W'(1);
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !count_we) |=> (count_q == $past(count_q) + CNT_W'(1))); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !count_we) |=> $stable(count_q)); // R3
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        count_we |=> (count_q == $past(wdata))); // R9
endmodule

// File: rtl/mct_status.sv
`timescale 1ns/1ps
// mct_status: shared pending-flag word, one bit per channel.
// Hardware sets a bit on a compare hit; software clears it by writing 1.
// When a set and a clear coincide on one bit, the set takes priority.
module mct_status #(
    parameter int NUM_CH = mct_pkg::MCT_NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_mask,
    input  logic [NUM_CH-1:0] hit,
    output logic [NUM_CH-1:0] status_q
);
    logic [NUM_CH-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_mask : '0;

    // Flag update: clear the written ones, then OR in the new hits
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_eff) | hit;
    end

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                hit[i] |=> status_q[i]); // R10
            AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_we && clr_mask[i] && !hit[i]) |=> !status_q[i]); // R7
            AST_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(status_q[i]) |-> $past(hit[i])); // R4
        end
    endgenerate
endmodule

// File: rtl/dual_match_timer.sv
`timescale 1ns/1ps
// dual_match_timer: two 32-bit compare channels sharing one W1C status word.
// Each interrupt line is its channel's pending flag gated by its enable bit.
// Assumes an undivided timer clock that also clocks the register port.
module dual_match_timer #(
    parameter int ADDR_W = mct_pkg::MCT_ADDR_W,
    parameter int DATA_W = mct_pkg::MCT_DATA_W,
    parameter int NUM_CH = mct_pkg::MCT_NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    import mct_pkg::*;
    localparam int CTRL_W = MCT_CTRL_W;

    logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_q;
    logic [NUM_CH-1:0][DATA_W-1:0] match_q;
    logic [NUM_CH-1:0][DATA_W-1:0] count_q;
    logic [NUM_CH-1:0]             status_q;
    logic [NUM_CH-1:0]             ctrl_we;
    logic [NUM_CH-1:0]             match_we;
    logic [NUM_CH-1:0]             count_we;
    logic                          status_we;
    logic [NUM_CH-1:0]             hit;
    logic [NUM_CH-1:0]             irq_en;

    mct_regif #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH), .CTRL_W(CTRL_W)
    ) u_regif (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .ctrl_q    (ctrl_q),
        .match_q   (match_q),
        .count_q   (count_q),
        .status_q  (status_q),
        .ctrl_we   (ctrl_we),
        .match_we  (match_we),
        .count_we  (count_we),
        .status_we (status_we),
        .bus_rdata (bus_rdata)
    );

    // One channel instance per timer, interrupt gated by its enable
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            mct_channel #(.CNT_W(DATA_W), .CTRL_W(CTRL_W)) u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .ctrl_we    (ctrl_we[c]),
                .match_we   (match_we[c]),
                .count_we   (count_we[c]),
                .ctrl_wdata (bus_wdata[CTRL_W-1:0]),
                .wdata      (bus_wdata),
                .ctrl_q     (ctrl_q[c]),
                .match_q    (match_q[c]),
                .count_q    (count_q[c]),
                .hit        (hit[c]),
                .irq_en     (irq_en[c])
            );
            assign irq[c] = status_q[c] && irq_en[c];
        end
    endgenerate

    mct_status #(.NUM_CH(NUM_CH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (status_we),
        .clr_mask (bus_wdata[NUM_CH-1:0]),
        .hit      (hit),
        .status_q (status_q)
    );
endmodule

// File: tb/sim_dual_match_timer.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module sim_dual_match_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_match_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [7:0] A_CTRL0 = 8'h00, A_CTRL1 = 8'h04;
    localparam logic [7:0] A_MAT0 = 8'h18, A_MAT1 = 8'h1C;
    localparam logic [7:0] A_CNT0 = 8'h48, A_CNT1 = 8'h4C;
    localparam logic [7:0] A_STAT = 8'h60;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_CTRL0, v); chk("R1 ctrl0", v, 0);
        rd(A_MAT1, v);  chk("R1 match1", v, 0);
        rd(A_CNT0, v);  chk("R1 count0", v, 0);
        rd(A_STAT, v);  chk("R1 status", v, 0);
        chk("R1 irq", {30'd0, irq}, 0);
    endtask

    task automatic t_ch0_delta5();
        logic [31:0] v;
        wr(A_CTRL0, 0); wr(A_CNT0, 0); wr(A_MAT0, 5); wr(A_CTRL0, 3);
        repeat (5) @(negedge clk);
        chk("R4 no flag before D+1 edges", {31'd0, irq[0]}, 0);
        @(negedge clk);
        chk("R4 irq0 after D+1 edges", {31'd0, irq[0]}, 1);
        rd(A_STAT, v); chk("R4 status bit0", v, 1);
        chk("R6 irq1 untouched", {31'd0, irq[1]}, 0);
        rd(A_CNT0, v); chk("R2 counter kept counting", v, 6);
    endtask

    task automatic t_ch1_min();
        logic [31:0] v;
        wr(A_CTRL1, 0); wr(A_CNT1, 0); wr(A_MAT1, 2); wr(A_CTRL1, 3);
        repeat (2) @(negedge clk);
        chk("R8 delta 2 not early", {31'd0, irq[1]}, 0);
        @(negedge clk);
        chk("R8 delta 2 fires on 3rd edge", {31'd0, irq[1]}, 1);
        rd(A_STAT, v); chk("R6 both flags", v, 3);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(A_STAT, 0);
        rd(A_STAT, v); chk("R7 zero write no effect", v, 3);
        wr(A_STAT, 1);
        rd(A_STAT, v); chk("R7 clear bit0 only", v, 2);
        chk("R7 irq after clear", {30'd0, irq}, 2);
        wr(A_STAT, 32'hFFFF);
        rd(A_STAT, v); chk("R7 clear all", v, 0);
    endtask

    task automatic t_stop();
        logic [31:0] a;
        logic [31:0] b;
        wr(A_CTRL0, 0);
        rd(A_CNT0, a);
        repeat (5) @(negedge clk);
        rd(A_CNT0, b);
        chk("R3 counter holds when stopped", b, a);
        chk("R3 irq0 low", {31'd0, irq[0]}, 0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(A_CNT0, 0); wr(A_MAT0, 3); wr(A_CTRL0, 1);
        repeat (4) @(negedge clk);
        rd(A_STAT, v); chk("R5 flag sets without IE", v & 1, 1);
        chk("R5 irq0 masked", {31'd0, irq[0]}, 0);
        wr(A_CTRL0, 3);
        chk("R5 irq0 follows IE", {31'd0, irq[0]}, 1);
        wr(A_STAT, 1);
        chk("R5 irq0 drops with flag", {31'd0, irq[0]}, 0);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(A_CTRL1, 0); wr(A_CNT1, 32'hFFFF_FFFF); wr(A_CTRL1, 1);
        rd(A_CNT1, v); chk("R2 at top", v, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(A_CNT1, v); chk("R2 wraps to zero", v, 0);
        wr(A_CTRL1, 0);
    endtask

    task automatic t_load_running();
        logic [31:0] v;
        wr(A_CNT0, 100);
        rd(A_CNT0, v); chk("R9 write beats increment", v, 100);
        @(negedge clk);
        rd(A_CNT0, v); chk("R2 resumes after load", v, 101);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        wr(A_CTRL0, 0); wr(A_STAT, 3); wr(A_CNT0, 50); wr(A_MAT0, 50);
        wr(A_CTRL0, 1);
        wr(A_STAT, 1);
        rd(A_STAT, v); chk("R10 set wins over clear", v & 1, 1);
        wr(A_STAT, 1);
        rd(A_STAT, v); chk("R7 later clear works", v & 1, 0);
        wr(A_CTRL0, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        rd(8'h30, v); chk("R11 hole reads zero", v, 0);
        rd(8'h62, v); chk("R11 misaligned reads zero", v, 0);
        wr(A_CTRL1, 32'hFFFF_FFF8);
        rd(A_CTRL1, v); chk("R11 only ctrl bits 2:0 kept", v, 0);
        rd(A_MAT0, v); chk("R11 match0 readback", v, 50);
        wr(8'h30, 32'h1234_5678);
        rd(A_MAT0, v); chk("R11 hole write ignored", v, 50);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ch0_delta5();
        t_ch1_min();
        t_w1c();
        t_stop();
        t_mask();
        t_wrap();
        t_load_running();
        t_set_wins();
        t_map();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule